// File: doc/BRIEF.md
# Bidirectional Frame Trace Recorder

This block sits between two frame decoders of a contactless link monitor, one decoding commands sent towards the card and one decoding the card's responses, and a byte-wide trace memory. It keeps a free-running sample counter. When a decoder reports a finished frame, the recorder writes one tagged record into the trace memory. The record holds a timestamp, the frame's 32-bit parity word, a length byte and the payload bytes. The recorder fetches the payload from the reporting decoder's buffer one byte per clock.

The timestamp is the sample count minus the offset that the decoder reports for its sync point. Response records are marked by forcing the top timestamp bit. After a command record, the recorder pulses both decoders back to their unsynced state, so that command traffic cannot leave the response decoder falsely triggered. After a response record, it pulses a full clear of the response decoder. Once a record leaves the write pointer beyond a fixed limit, capture stops until the next reset.

After reset the whole trace region is first filled with a known background byte. While that fill runs, while a record is being written, and after capture has stopped, a busy output tells the decoders that new frames will not be taken.

Top module: `frame_trace_recorder`

## Requirements
- R1: After reset, the recorder writes the byte 0x44 to every address from 0 to TRACE_BYTES-1, one address per clock in rising order. busy is high during this fill.
- R2: The sample counter is cleared by reset and advances by one on each clock edge at which smp_en is high. A record's timestamp is the counter value in the cycle its done pulse is taken, minus that decoder's offset, modulo 2^32.
- R3: A record occupies consecutive addresses starting at the write pointer. Bytes 0 to 3 are the timestamp, least significant byte first. Bytes 4 to 7 are the parity word, least significant byte first. Byte 8 is the length. Then come the payload bytes, read from the decoder with pay_idx counting 0 to length-1, one byte per clock.
- R4: In a response record, bit 7 of timestamp byte 3 is forced to 1. In a command record, that bit is written as computed.
- R5: When both done inputs are taken in the same cycle, the command record is written first and the response record directly after it.
- R6: A done pulse is taken only in a cycle where busy is low. A frame reported while busy is high leaves no trace in memory and produces no pulse.
- R7: The cycle after the last byte of a command record, cmd_unsync and rsp_unsync are both high for exactly one cycle.
- R8: The cycle after the last byte of a response record, rsp_clear is high for exactly one cycle, and cmd_unsync is not.
- R9: If, after a record, the write pointer is greater than STOP_LIMIT, recording stops until reset. busy then stays high, nothing more is written, and a record still queued is dropped.
- R10: A record byte whose address is TRACE_BYTES or above is not written, but the write pointer still advances past it.
- R11: A frame of length 0 produces a 9-byte record with no payload reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe; advances the sample counter |
| cmd_done | input | 1 | Command decoder finished a frame (one-cycle pulse) |
| cmd_offset | input | 32 | Samples between the command sync point and now |
| cmd_parity | input | 32 | Parity word of the command frame |
| cmd_len | input | 8 | Payload length of the command frame |
| cmd_pay_data | input | 8 | Command buffer byte at pay_idx |
| rsp_done | input | 1 | Response decoder finished a frame (one-cycle pulse) |
| rsp_offset | input | 32 | Samples between the response sync point and now |
| rsp_parity | input | 32 | Parity word of the response frame |
| rsp_len | input | 8 | Payload length of the response frame |
| rsp_pay_data | input | 8 | Response buffer byte at pay_idx |
| pay_idx | output | 8 | Payload byte index read from the active decoder |
| cmd_unsync | output | 1 | Return command decoder to unsynced |
| rsp_unsync | output | 1 | Return response decoder to unsynced |
| rsp_clear | output | 1 | Fully clear the response decoder |
| busy | output | 1 | New frames are not taken |
| tr_we | output | 1 | Trace memory write enable |
| tr_addr | output | $clog2(TRACE_BYTES) | Trace memory byte address |
| tr_wdata | output | 8 | Trace memory write byte |

## Verification
The bench builds the block with TRACE_BYTES = 300 and STOP_LIMIT = 240. With these values the background fill is short, and a run of a few dozen frames reaches the stop limit. A final long command record then runs past the end of the 300-byte region, so the dropped tail and the discarding of a queued response both happen inside one run. A 9-bit address makes out-of-region writes visible at the port if they occurred.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_IDLE,
    ST_HEAD,
    ST_BODY,
    ST_FIN,
    ST_HALT
  } trc_state_e;

  typedef struct packed {
    logic [31:0] stamp;
    logic [31:0] parity;
    logic [7:0]  len;
  } trc_meta_t;

  localparam logic [7:0] FILL_BYTE = 8'h44;
  localparam int         HDR_BYTES = 9;

endpackage

// File: rtl/trc_sample_clock.sv
module trc_sample_clock #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (smp_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/trc_frame_slot.sv
module trc_frame_slot
  import trc_pkg::*;
#(
  parameter bit FORCE_DIR = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        release_i,
  input  logic [31:0] count,
  input  logic [31:0] offset,
  input  logic [31:0] parity,
  input  logic [7:0]  len,
  output logic        valid,
  output trc_meta_t   meta
);
  logic        valid_q, valid_d;
  trc_meta_t   meta_q, meta_d;
  logic [31:0] raw_stamp;
  logic [31:0] stamp;

  assign raw_stamp = count - offset;

  generate
    if (FORCE_DIR) begin : g_dir_set
      assign stamp = {1'b1, raw_stamp[30:0]};
    end else begin : g_dir_keep
      assign stamp = raw_stamp;
    end
  endgenerate

  always_comb begin
    valid_d = valid_q;
    meta_d  = meta_q;
    if (release_i) valid_d = 1'b0;
    if (capture) begin
      valid_d       = 1'b1;
      meta_d.stamp  = stamp;
      meta_d.parity = parity;
      meta_d.len    = len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      meta_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (capture) meta_q <= meta_d;
    end
  end

  assign valid = valid_q;
  assign meta  = meta_q;
endmodule

// File: rtl/trc_byte_sel.sv
module trc_byte_sel
  import trc_pkg::*;
(
  input  trc_meta_t  meta,
  input  logic [3:0] idx,
  output logic [7:0] hdr_byte
);
  always_comb begin
    case (idx)
      4'd0:    hdr_byte = meta.stamp[7:0];
      4'd1:    hdr_byte = meta.stamp[15:8];
      4'd2:    hdr_byte = meta.stamp[23:16];
      4'd3:    hdr_byte = meta.stamp[31:24];
      4'd4:    hdr_byte = meta.parity[7:0];
      4'd5:    hdr_byte = meta.parity[15:8];
      4'd6:    hdr_byte = meta.parity[23:16];
      4'd7:    hdr_byte = meta.parity[31:24];
      default: hdr_byte = meta.len;
    endcase
  end
endmodule

// File: rtl/trc_record_ctrl.sv
module trc_record_ctrl
  import trc_pkg::*;
#(
  parameter int TRACE_BYTES = 3032,
  parameter int STOP_LIMIT  = 3000,
  parameter int AW          = 12,
  parameter int PW          = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          rsp_valid,
  input  trc_meta_t     cmd_meta,
  input  trc_meta_t     rsp_meta,
  input  logic [7:0]    cmd_pay,
  input  logic [7:0]    rsp_pay,
  output logic          accept,
  output logic          cmd_release,
  output logic          rsp_release,
  output logic          cmd_unsync,
  output logic          rsp_unsync,
  output logic          rsp_clear,
  output logic [7:0]    pay_idx,
  output logic          tr_we,
  output logic [AW-1:0] tr_addr,
  output logic [7:0]    tr_wdata
);
  localparam logic [AW-1:0] FILL_LAST = AW'(TRACE_BYTES - 1);
  localparam logic [PW-1:0] REGION_P  = PW'(TRACE_BYTES);
  localparam logic [PW-1:0] LIMIT_P   = PW'(STOP_LIMIT);
  localparam logic [7:0]    HDR_LAST  = 8'(HDR_BYTES - 1);

  trc_state_e    state_q, state_d;
  logic [AW-1:0] fill_q, fill_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic [7:0]    idx_q, idx_d;
  logic          sel_q, sel_d;

  trc_meta_t     act_meta;
  logic [7:0]    act_pay;
  logic [7:0]    hdr_byte;
  logic          in_region;

  assign act_meta  = sel_q ? rsp_meta : cmd_meta;
  assign act_pay   = sel_q ? rsp_pay  : cmd_pay;
  assign in_region = (ptr_q < REGION_P);

  trc_byte_sel u_byte_sel (
    .meta     (act_meta),
    .idx      (idx_q[3:0]),
    .hdr_byte (hdr_byte)
  );

  always_comb begin
    state_d     = state_q;
    fill_d      = fill_q;
    ptr_d       = ptr_q;
    idx_d       = idx_q;
    sel_d       = sel_q;
    tr_we       = 1'b0;
    tr_addr     = ptr_q[AW-1:0];
    tr_wdata    = hdr_byte;
    pay_idx     = 8'd0;
    cmd_release = 1'b0;
    rsp_release = 1'b0;
    cmd_unsync  = 1'b0;
    rsp_unsync  = 1'b0;
    rsp_clear   = 1'b0;
    case (state_q)
      ST_FILL: begin
        tr_we    = 1'b1;
        tr_addr  = fill_q;
        tr_wdata = FILL_BYTE;
        fill_d   = fill_q + AW'(1);
        if (fill_q == FILL_LAST) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        idx_d = 8'd0;
        if (cmd_valid) begin
          state_d = ST_HEAD;
          sel_d   = 1'b0;
        end else if (rsp_valid) begin
          state_d = ST_HEAD;
          sel_d   = 1'b1;
        end
      end
      ST_HEAD: begin
        tr_we = in_region;
        ptr_d = ptr_q + PW'(1);
        if (idx_q == HDR_LAST) begin
          idx_d   = 8'd0;
          state_d = (act_meta.len == 8'd0) ? ST_FIN : ST_BODY;
        end else begin
          idx_d = idx_q + 8'd1;
        end
      end
      ST_BODY: begin
        pay_idx  = idx_q;
        tr_wdata = act_pay;
        tr_we    = in_region;
        ptr_d    = ptr_q + PW'(1);
        if (idx_q == act_meta.len - 8'd1) state_d = ST_FIN;
        else                              idx_d   = idx_q + 8'd1;
      end
      ST_FIN: begin
        if (!sel_q) begin
          cmd_release = 1'b1;
          cmd_unsync  = 1'b1;
          rsp_unsync  = 1'b1;
        end else begin
          rsp_release = 1'b1;
          rsp_clear   = 1'b1;
        end
        if (ptr_q > LIMIT_P) begin
          state_d     = ST_HALT;
          cmd_release = 1'b1;
          rsp_release = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HALT: begin
        state_d = ST_HALT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign accept = (state_q == ST_IDLE) && !cmd_valid && !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      fill_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fill_q  <= fill_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      sel_q   <= sel_d;
    end
  end
endmodule

// File: rtl/frame_trace_recorder.sv
module frame_trace_recorder
  import trc_pkg::*;
#(
  parameter  int TRACE_BYTES = 3032,
  parameter  int STOP_LIMIT  = 3000,
  localparam int AW          = $clog2(TRACE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          cmd_done,
  input  logic [31:0]   cmd_offset,
  input  logic [31:0]   cmd_parity,
  input  logic [7:0]    cmd_len,
  input  logic [7:0]    cmd_pay_data,
  input  logic          rsp_done,
  input  logic [31:0]   rsp_offset,
  input  logic [31:0]   rsp_parity,
  input  logic [7:0]    rsp_len,
  input  logic [7:0]    rsp_pay_data,
  output logic [7:0]    pay_idx,
  output logic          cmd_unsync,
  output logic          rsp_unsync,
  output logic          rsp_clear,
  output logic          busy,
  output logic          tr_we,
  output logic [AW-1:0] tr_addr,
  output logic [7:0]    tr_wdata
);
  localparam int TOP_SPAN = (TRACE_BYTES > STOP_LIMIT) ? TRACE_BYTES : STOP_LIMIT;
  localparam int PW       = $clog2(TOP_SPAN + HDR_BYTES + 257);

  logic [31:0] count;
  logic        accept;
  logic        cmd_valid, rsp_valid;
  logic        cmd_release, rsp_release;
  trc_meta_t   cmd_meta, rsp_meta;

  trc_sample_clock #(.CW(32)) u_clock (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .count  (count)
  );

  trc_frame_slot #(.FORCE_DIR(1'b0)) u_cmd_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (cmd_done && accept),
    .release_i (cmd_release),
    .count     (count),
    .offset    (cmd_offset),
    .parity    (cmd_parity),
    .len       (cmd_len),
    .valid     (cmd_valid),
    .meta      (cmd_meta)
  );

  trc_frame_slot #(.FORCE_DIR(1'b1)) u_rsp_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rsp_done && accept),
    .release_i (rsp_release),
    .count     (count),
    .offset    (rsp_offset),
    .parity    (rsp_parity),
    .len       (rsp_len),
    .valid     (rsp_valid),
    .meta      (rsp_meta)
  );

  trc_record_ctrl #(
    .TRACE_BYTES (TRACE_BYTES),
    .STOP_LIMIT  (STOP_LIMIT),
    .AW          (AW),
    .PW          (PW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .rsp_valid   (rsp_valid),
    .cmd_meta    (cmd_meta),
    .rsp_meta    (rsp_meta),
    .cmd_pay     (cmd_pay_data),
    .rsp_pay     (rsp_pay_data),
    .accept      (accept),
    .cmd_release (cmd_release),
    .rsp_release (rsp_release),
    .cmd_unsync  (cmd_unsync),
    .rsp_unsync  (rsp_unsync),
    .rsp_clear   (rsp_clear),
    .pay_idx     (pay_idx),
    .tr_we       (tr_we),
    .tr_addr     (tr_addr),
    .tr_wdata    (tr_wdata)
  );

  assign busy = !accept;
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          tr_we,
  input logic [AW-1:0] tr_addr,
  input logic          cmd_unsync,
  input logic          rsp_unsync,
  input logic          rsp_clear
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R6: nothing is written while frames are being taken
  a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tr_we);

  // R7: both decoders are released together, never with the response clear
  a_r7_unsync_pair: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unsync |-> (rsp_unsync && !rsp_clear));

  // R7: the release pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unsync |=> !cmd_unsync);

  // R8: the clear pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_clear |=> !rsp_clear);

  // R3: back-to-back writes go to consecutive addresses
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tr_we && $past(tr_we)) |-> (tr_addr == $past(tr_addr) + AW'(1)));

  // R8: no write in the cycle a record is closed
  a_r8_close_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_clear || rsp_unsync) |-> !tr_we);
endmodule

bind frame_trace_recorder trc_checker #(.AW(AW)) u_trc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .tr_we      (tr_we),
  .tr_addr    (tr_addr),
  .cmd_unsync (cmd_unsync),
  .rsp_unsync (rsp_unsync),
  .rsp_clear  (rsp_clear)
);

// File: tb/frame_trace_recorder_bench.sv
`timescale 1ns/1ps
module frame_trace_recorder_bench;
  localparam int TB  = 300;
  localparam int LIM = 240;
  localparam int AW  = $clog2(TB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_en;
  logic          cmd_done, rsp_done;
  logic [31:0]   cmd_offset, cmd_parity, rsp_offset, rsp_parity;
  logic [7:0]    cmd_len, rsp_len;
  logic [7:0]    cmd_pay_data, rsp_pay_data;
  logic [7:0]    pay_idx;
  logic          cmd_unsync, rsp_unsync, rsp_clear, busy, tr_we;
  logic [AW-1:0] tr_addr;
  logic [7:0]    tr_wdata;

  logic [7:0] cmd_buf [256];
  logic [7:0] rsp_buf [256];
  logic [7:0] mem     [TB];
  logic [7:0] exp_mem [TB];

  int          n_chk, n_fail;
  int          exp_ptr, exp_cmd, exp_rsp;
  bit          exp_halt;
  int          oob, cmd_p, rsp_up, rsp_cl, gap_bad;
  bit          prev_we, gap_on, finished;
  int unsigned mcnt;

  always #2.5 clk = ~clk;

  assign cmd_pay_data = cmd_buf[pay_idx];
  assign rsp_pay_data = rsp_buf[pay_idx];

  frame_trace_recorder #(.TRACE_BYTES(TB), .STOP_LIMIT(LIM)) u_frame_trace_recorder (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
    .cmd_done(cmd_done), .cmd_offset(cmd_offset), .cmd_parity(cmd_parity),
    .cmd_len(cmd_len), .cmd_pay_data(cmd_pay_data),
    .rsp_done(rsp_done), .rsp_offset(rsp_offset), .rsp_parity(rsp_parity),
    .rsp_len(rsp_len), .rsp_pay_data(rsp_pay_data),
    .pay_idx(pay_idx), .cmd_unsync(cmd_unsync), .rsp_unsync(rsp_unsync),
    .rsp_clear(rsp_clear), .busy(busy), .tr_we(tr_we), .tr_addr(tr_addr),
    .tr_wdata(tr_wdata)
  );

  // sample counter model (R2)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mcnt <= 0;
    else if (smp_en) mcnt <= mcnt + 1;
  end

  always @(negedge clk) smp_en <= (($urandom % 4) != 0);

  // memory and pulse observer
  always @(posedge clk) begin
    if (rst_n) begin
      if (tr_we) begin
        if (int'(tr_addr) < TB) mem[tr_addr] = tr_wdata;
        else oob++;
      end
      if (cmd_unsync) begin
        cmd_p++;
        if (!prev_we && gap_on) gap_bad++;
      end
      if (rsp_unsync) rsp_up++;
      if (rsp_clear) begin
        rsp_cl++;
        if (!prev_we && gap_on) gap_bad++;
      end
    end
    prev_we <= tr_we;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    if (exp_ptr < TB) exp_mem[exp_ptr] = b;
    exp_ptr++;
  endtask

  task automatic push_record(bit rsp, logic [31:0] stamp, logic [31:0] par, logic [7:0] len);
    logic [31:0] s;
    if (exp_halt) return;
    s = stamp;
    if (rsp) s[31] = 1'b1;
    for (int i = 0; i < 4; i++) put(s[8*i +: 8]);
    for (int i = 0; i < 4; i++) put(par[8*i +: 8]);
    put(len);
    for (int i = 0; i < int'(len); i++) put(rsp ? rsp_buf[i] : cmd_buf[i]);
    if (rsp) exp_rsp++; else exp_cmd++;
    if (exp_ptr > LIM) exp_halt = 1'b1;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic compare_image(string req, string what);
    int bad;
    longint a, e;
    bad = -1;
    a = 0;
    e = 0;
    for (int i = 0; i < TB; i++)
      if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad >= 0) begin
      a = mem[bad];
      e = exp_mem[bad];
    end
    check(bad < 0, req, $sformatf("%s byte @%0d", what, bad), a, e);
  endtask

  // take: the frame is expected to be accepted
  task automatic send(bit c, bit r, logic [31:0] coff, logic [31:0] roff,
                      logic [7:0] clen, logic [7:0] rlen, bit wait_first, bit take);
    logic [31:0] cpar, rpar;
    int unsigned cnt;
    if (wait_first) wait_idle();
    else @(negedge clk);
    cpar = $urandom;
    rpar = $urandom;
    if (c && take) for (int i = 0; i < int'(clen); i++) cmd_buf[i] = 8'($urandom);
    if (r && take) for (int i = 0; i < int'(rlen); i++) rsp_buf[i] = 8'($urandom);
    cnt = mcnt;
    cmd_done = c; cmd_offset = coff; cmd_parity = cpar; cmd_len = clen;
    rsp_done = r; rsp_offset = roff; rsp_parity = rpar; rsp_len = rlen;
    @(negedge clk);
    cmd_done = 1'b0;
    rsp_done = 1'b0;
    if (take) begin
      if (c) push_record(1'b0, cnt - coff, cpar, clen);
      if (r) push_record(1'b1, cnt - roff, rpar, rlen);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < TB; i++) begin
      exp_mem[i] = 8'h44;
      mem[i] = 8'h00;
    end
    rst_n = 1'b0;
    cmd_done = 0; rsp_done = 0; cmd_offset = 0; rsp_offset = 0;
    cmd_parity = 0; rsp_parity = 0; cmd_len = 0; rsp_len = 0;
    gap_on = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R1", "busy in reset", busy, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy === 1'b1, "R1", "busy during fill", busy, 1);
    wait_idle();
    compare_image("R1", "background fill");

    // directed
    send(1, 0, 32'd5, 0, 8'd4, 0, 1, 1);
    wait_idle(); compare_image("R2/R3", "command record");
    send(0, 1, 0, 32'd0, 0, 8'd3, 1, 1);
    wait_idle(); compare_image("R4", "response record");
    send(1, 0, 32'hFFFF_FF00, 0, 8'd2, 0, 1, 1);
    wait_idle(); compare_image("R2", "wrapped stamp");
    send(1, 0, 32'd1, 0, 8'd0, 0, 1, 1);
    wait_idle(); compare_image("R11", "empty command");
    send(0, 1, 0, 32'd2, 0, 8'd0, 1, 1);
    wait_idle(); compare_image("R11", "empty response");
    send(1, 1, 32'd3, 32'd7, 8'd2, 8'd2, 1, 1);
    wait_idle(); compare_image("R5", "simultaneous order");
    send(1, 0, 32'd0, 0, 8'd10, 0, 1, 1);
    send(0, 1, 0, 32'd0, 0, 8'd5, 0, 0);
    wait_idle(); compare_image("R6", "frame during busy");
    check(rsp_cl == exp_rsp, "R6", "clear pulses", rsp_cl, exp_rsp);
    check(cmd_p == exp_cmd, "R7", "command release pulses", cmd_p, exp_cmd);
    check(rsp_up == exp_cmd, "R7", "response unsync pulses", rsp_up, exp_cmd);
    check(rsp_cl == exp_rsp, "R8", "response clear pulses", rsp_cl, exp_rsp);
    check(gap_bad == 0, "R7", "pulse timing", gap_bad, 0);

    // random traffic
    while (exp_ptr <= 170) begin
      int pick;
      pick = $urandom % 3;
      send(pick != 1, pick != 0, $urandom % 64, $urandom % 64,
           8'($urandom % 7), 8'($urandom % 7), 1, 1);
      wait_idle();
      compare_image("R3", "random record");
    end
    check(gap_bad == 0, "R8", "pulse timing random", gap_bad, 0);

    // overrun: long command crosses limit and region end, response queued
    gap_on = 1'b0;
    send(1, 1, 32'd9, 32'd9, 8'd140, 8'd4, 1, 1);
    repeat (400) @(negedge clk);
    compare_image("R10", "truncated record");
    check(oob == 0, "R10", "writes beyond region", oob, 0);
    check(busy === 1'b1, "R9", "busy after stop", busy, 1);
    check(rsp_cl == exp_rsp, "R9", "queued response dropped", rsp_cl, exp_rsp);
    send(1, 0, 0, 0, 8'd3, 0, 0, 0);
    repeat (50) @(negedge clk);
    compare_image("R9", "no write after stop");
    check(cmd_p == exp_cmd, "R9", "no pulse after stop", cmd_p, exp_cmd);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule